// File: doc/BRIEF.md
# ADC Channel Result Register Bank

This block keeps the most recent conversion result for each of 96 analog channels. A conversion engine pushes each finished sample into the bank with a one-cycle strobe that carries the channel number, the 10-bit value and a 2-bit mode tag. A processor reads any channel through a simple word-addressed register port. Each channel is one 32-bit word that carries the value, the tag and two status flags. Channels 0 to 31 are the standard set, 32 to 63 are extended internal inputs and 64 to 95 are external inputs. All of them behave the same way.

Each channel has a fresh-data flag that a store sets and a read clears. A global overwrite-enable input selects how a new sample treats a channel that still holds unread data. With the input low, the unread sample is protected and the new one is dropped. With the input high, the new sample replaces the old one and a lost-data flag records the loss. A read clears both flags of the channel it addresses.

Top module: `adc_result_bank`

## Requirements
- R1: After reset every channel reads as 0. A read made while reset is asserted returns 0 in the cycle after.
- R2: The read word places the value in bits 9:0, the tag in bits 17:16, the lost-data flag in bit 18 and the fresh-data flag in bit 19. Every other bit reads 0. The word index is byte address bits 8:2, and address bits 1:0 are ignored.
- R3: A conversion strobe to a channel whose fresh flag is 0 stores the value and the tag and sets the fresh flag.
- R4: A read clears the fresh flag and the lost-data flag of that channel. The value and the tag are kept.
- R5: With overwrite-enable low, a strobe to a channel whose fresh flag is 1 is discarded, and the lost-data flag is never set.
- R6: With overwrite-enable high, a strobe always stores. The lost-data flag becomes 1 if the fresh flag was 1 and 0 otherwise, and it stays set through further overwrites until a read.
- R7: When a read and a strobe hit the same channel in one cycle, the read returns the old contents. The channel then holds the new sample with the fresh flag at 1 and the lost-data flag at 0.
- R8: A strobe whose channel index is 96 or more changes no channel.
- R9: A read of a word index of 96 or more returns 0 and changes no state.
- R10: Processor writes are accepted but change no field of any channel and return no data.
- R11: Read data appears in the cycle after the read strobe. In a cycle that follows no read, the read data is 0.
- R12: A strobe or a read affects only the channel it addresses. This includes the neighbours at the 63/64 boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovw_en | input | 1 | 1: new samples replace unread data and flag the loss; 0: unread data is protected |
| cv_strobe | input | 1 | One-cycle conversion-result strobe |
| cv_chan | input | 7 | Channel index of the result |
| cv_data | input | 10 | Conversion value |
| cv_tag | input | 2 | Result mode tag |
| bus_rd | input | 1 | Processor read strobe |
| bus_wr | input | 1 | Processor write strobe (has no effect) |
| bus_addr | input | 9 | Byte address; bits 8:2 select the channel word |
| bus_wdata | input | 32 | Processor write data (ignored) |
| bus_rdata | output | 32 | Registered read word |

## Verification
A processor read and a conversion store can both land on one channel in the same cycle. That is where the read-to-clear rule meets the set-on-store rule. The bench provokes this by first storing a sample, then driving a read and a second strobe to that channel in one cycle. It judges the result in two steps. The returned word must carry the first sample with its fresh flag set. A second read must then show the second sample, with the fresh flag set and the lost-data flag clear.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;

    localparam int NUM_CH   = 96;
    localparam int DATA_W   = 10;
    localparam int TAG_W    = 2;
    localparam int BUS_W    = 32;

    // bit positions of the packed read word
    localparam int DATA_LSB = 0;
    localparam int TAG_LSB  = 16;
    localparam int LOST_BIT = 18;
    localparam int NEW_BIT  = 19;

    typedef struct packed {
        logic              fresh;
        logic              lost;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } slot_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } sample_t;

    typedef enum logic [1:0] {
        ACT_KEEP,
        ACT_STORE,
        ACT_STORE_LOST,
        ACT_CLEAR
    } slot_act_e;

    function automatic logic [BUS_W-1:0] pack_word(input slot_t s);
        logic [BUS_W-1:0] w;
        w = '0;
        w[DATA_LSB +: DATA_W] = s.value;
        w[TAG_LSB  +: TAG_W]  = s.tag;
        w[LOST_BIT]           = s.lost;
        w[NEW_BIT]            = s.fresh;
        return w;
    endfunction

    // per-slot update decision
    function automatic slot_act_e pick_act(input logic wr, input logic rd,
                                           input logic ovw, input logic fresh);
        slot_act_e a;
        if (wr && rd)       a = ACT_STORE;
        else if (wr && ovw) a = fresh ? ACT_STORE_LOST : ACT_STORE;
        else if (wr)        a = fresh ? ACT_KEEP : ACT_STORE;
        else if (rd)        a = ACT_CLEAR;
        else                a = ACT_KEEP;
        return a;
    endfunction

endpackage

// File: rtl/chan_decode.sv
module chan_decode #(
    parameter int N    = 96,
    parameter int IW   = 7
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  hit
);
    for (genvar g = 0; g < N; g++) begin : g_dec
        assign hit[g] = en && (idx == IW'(g));
    end
endmodule

// File: rtl/result_slot.sv
module result_slot
    import adc_result_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ovw_en,
    input  logic    wr,
    input  logic    rd,
    input  sample_t smp,
    output slot_t   q
);
    slot_act_e act;

    always_comb act = pick_act(wr, rd, ovw_en, q.fresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (act)
                ACT_STORE: begin
                    q.value <= smp.value;
                    q.tag   <= smp.tag;
                    q.fresh <= 1'b1;
                    q.lost  <= 1'b0;
                end
                ACT_STORE_LOST: begin
                    q.value <= smp.value;
                    q.tag   <= smp.tag;
                    q.fresh <= 1'b1;
                    q.lost  <= 1'b1;
                end
                ACT_CLEAR: begin
                    q.fresh <= 1'b0;
                    q.lost  <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/result_rd_mux.sv
module result_rd_mux
    import adc_result_pkg::*;
#(
    parameter int N = 96
) (
    input  slot_t [N-1:0]    slots,
    input  logic  [N-1:0]    sel,
    output logic [BUS_W-1:0] word
);
    always_comb begin
        word = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) word = word | pack_word(slots[i]);
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_result_pkg::*;
#(
    parameter  int N_CH   = NUM_CH,
    localparam int CH_W   = $clog2(N_CH),
    localparam int ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ovw_en,
    input  logic              cv_strobe,
    input  logic [CH_W-1:0]   cv_chan,
    input  logic [DATA_W-1:0] cv_data,
    input  logic [TAG_W-1:0]  cv_tag,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic [CH_W-1:0]  word_idx;
    logic [N_CH-1:0]  wr_hit;
    logic [N_CH-1:0]  rd_hit;
    slot_t [N_CH-1:0] slots;
    sample_t          smp;
    logic [BUS_W-1:0] rd_word;
    logic             unused_bus;

    assign word_idx   = bus_addr[ADDR_W-1:2];
    assign smp        = '{tag: cv_tag, value: cv_data};
    assign unused_bus = ^{bus_wr, bus_wdata, bus_addr[1:0]};

    chan_decode #(.N(N_CH), .IW(CH_W)) u_wr_dec (
        .en (cv_strobe),
        .idx(cv_chan),
        .hit(wr_hit)
    );

    chan_decode #(.N(N_CH), .IW(CH_W)) u_rd_dec (
        .en (bus_rd),
        .idx(word_idx),
        .hit(rd_hit)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_slot
        result_slot u_slot (
            .clk   (clk),
            .rst   (rst),
            .ovw_en(ovw_en),
            .wr    (wr_hit[c]),
            .rd    (rd_hit[c]),
            .smp   (smp),
            .q     (slots[c])
        );
    end

    result_rd_mux #(.N(N_CH)) u_mux (
        .slots(slots),
        .sel  (rd_hit),
        .word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_word;
    end
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
    parameter int N_CH = 96,
    parameter int CH_W = 7
) (
    input logic        clk,
    input logic        rst,
    input logic        ovw_en,
    input logic        cv_strobe,
    input logic [CH_W-1:0] cv_chan,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [CH_W-1:0] rd_idx,
    input logic [31:0] bus_rdata
);
    logic            prev_rd;
    logic [CH_W-1:0] prev_idx;
    logic            prev_hit;
    logic            ovw_ever;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rd  <= 1'b0;
            prev_idx <= '0;
            prev_hit <= 1'b0;
            ovw_ever <= 1'b0;
        end else begin
            prev_rd  <= bus_rd;
            prev_idx <= rd_idx;
            prev_hit <= cv_strobe && (cv_chan == rd_idx);
            ovw_ever <= ovw_ever | ovw_en;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (bus_rdata == 32'd0));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[31:20] == 12'd0) && (bus_rdata[15:10] == 6'd0));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && prev_rd && rd_idx == prev_idx && !prev_hit)
        |=> (!bus_rdata[19] && !bus_rdata[18]));

    assert_no_loss_flag_R5: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[18] |-> ovw_ever);

    assert_loss_needs_fresh_R6: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[18] |-> bus_rdata[19]);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && rd_idx >= CH_W'(N_CH)) |=> (bus_rdata == 32'd0));

    assert_write_silent_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd) |=> (bus_rdata == 32'd0));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 32'd0));
endmodule

bind adc_result_bank adc_result_bank_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ovw_en   (ovw_en),
    .cv_strobe(cv_strobe),
    .cv_chan  (cv_chan),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rd_idx   (bus_addr[ADDR_W-1:2]),
    .bus_rdata(bus_rdata)
);

// File: tb/adc_result_bank_bench.sv
`timescale 1ns/1ps
module adc_result_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ovw_en = 1'b0;
    logic        cv_strobe = 1'b0;
    logic [6:0]  cv_chan = '0;
    logic [9:0]  cv_data = '0;
    logic [1:0]  cv_tag = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adc_result_bank u_adc_result_bank (
        .clk(clk), .rst(rst), .ovw_en(ovw_en),
        .cv_strobe(cv_strobe), .cv_chan(cv_chan), .cv_data(cv_data), .cv_tag(cv_tag),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // vector: kind(2) ovw(1) idx(7) data(10) tag(2) expected(32)
    // kind 0 = conversion strobe, 1 = read and compare, 2 = processor write
    localparam int NV = 24;
    localparam logic [53:0] VECS [NV] = '{
        {2'd1, 1'b0, 7'd5,   10'h000, 2'd0, 32'h00000000},  // R1 fresh reset
        {2'd0, 1'b0, 7'd5,   10'h155, 2'd2, 32'h0},          // R3
        {2'd1, 1'b0, 7'd5,   10'h000, 2'd0, 32'h000A0155},  // R3 R2
        {2'd1, 1'b0, 7'd5,   10'h000, 2'd0, 32'h00020155},  // R4
        {2'd0, 1'b0, 7'd40,  10'h3FF, 2'd1, 32'h0},
        {2'd0, 1'b0, 7'd40,  10'h001, 2'd3, 32'h0},          // R5 dropped
        {2'd1, 1'b0, 7'd40,  10'h000, 2'd0, 32'h000903FF},  // R5
        {2'd0, 1'b1, 7'd70,  10'h0AA, 2'd0, 32'h0},
        {2'd0, 1'b1, 7'd70,  10'h2CC, 2'd3, 32'h0},          // R6 overwrite
        {2'd1, 1'b0, 7'd70,  10'h000, 2'd0, 32'h000F02CC},  // R6
        {2'd1, 1'b0, 7'd70,  10'h000, 2'd0, 32'h000302CC},  // R4
        {2'd0, 1'b1, 7'd95,  10'h123, 2'd1, 32'h0},          // R6 no loss
        {2'd1, 1'b0, 7'd95,  10'h000, 2'd0, 32'h00090123},  // R6
        {2'd0, 1'b1, 7'd96,  10'h3FF, 2'd3, 32'h0},          // R8
        {2'd0, 1'b1, 7'd127, 10'h111, 2'd1, 32'h0},          // R8
        {2'd1, 1'b0, 7'd96,  10'h000, 2'd0, 32'h00000000},  // R9
        {2'd1, 1'b0, 7'd0,   10'h000, 2'd0, 32'h00000000},  // R8
        {2'd1, 1'b0, 7'd95,  10'h000, 2'd0, 32'h00010123},  // R8
        {2'd2, 1'b0, 7'd70,  10'h000, 2'd0, 32'h00000000},  // R10 write
        {2'd1, 1'b0, 7'd70,  10'h000, 2'd0, 32'h000302CC},  // R10
        {2'd0, 1'b0, 7'd63,  10'h200, 2'd2, 32'h0},
        {2'd1, 1'b0, 7'd64,  10'h000, 2'd0, 32'h00000000},  // R12
        {2'd1, 1'b0, 7'd62,  10'h000, 2'd0, 32'h00000000},  // R12
        {2'd1, 1'b0, 7'd63,  10'h000, 2'd0, 32'h000A0200}   // R12
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic conv(input logic ovw, input logic [6:0] ch, input logic [9:0] d, input logic [1:0] t);
        @(negedge clk);
        ovw_en = ovw; cv_strobe = 1'b1; cv_chan = ch; cv_data = d; cv_tag = t;
        @(negedge clk);
        cv_strobe = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [8:0] addr, input logic [31:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = addr;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic cpu_wr(input logic [6:0] idx);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {idx, 2'b00}; bus_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 write returns nothing", bus_rdata, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        bus_rd = 1'b1; bus_addr = {7'd5, 2'b00};
        @(negedge clk);
        bus_rd = 1'b0;
        check("R1 read under reset", bus_rdata, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [53:0] v;
            v = VECS[i];
            case (v[53:52])
                2'd0: conv(v[51], v[50:44], v[43:34], v[33:32]);
                2'd1: rd_chk("R-table vector", {v[50:44], 2'b00}, v[31:0]);
                default: cpu_wr(v[50:44]);
            endcase
        end

        // R7 same-cycle read and store on one channel
        conv(1'b0, 7'd20, 10'h0F0, 2'd1);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = {7'd20, 2'b00};
        cv_strobe = 1'b1; cv_chan = 7'd20; cv_data = 10'h30F; cv_tag = 2'd2;
        @(negedge clk);
        bus_rd = 1'b0; cv_strobe = 1'b0;
        check("R7 collision returns old", bus_rdata, 32'h000900F0);
        rd_chk("R7 collision stores new", {7'd20, 2'b00}, 32'h000A030F);

        // R9 unmapped read leaves state alone; R2 low address bits ignored
        conv(1'b0, 7'd10, 10'h055, 2'd0);
        rd_chk("R9 unmapped word", {7'd100, 2'b00}, 32'h0);
        rd_chk("R2 R9 byte offset ignored", {7'd10, 2'b11}, 32'h00080055);

        // R11 no read, no data
        @(negedge clk);
        check("R11 idle read data", bus_rdata, 32'h0);

        // R6 sticky loss over several overwrites
        conv(1'b1, 7'd33, 10'h001, 2'd0);
        conv(1'b1, 7'd33, 10'h002, 2'd0);
        conv(1'b1, 7'd33, 10'h003, 2'd0);
        rd_chk("R6 sticky loss", {7'd33, 2'b00}, 32'h000C0003);

        // R8 out-of-range index must not alias onto a low channel
        conv(1'b1, 7'd100, 10'h3AA, 2'd3);
        rd_chk("R8 no alias ch36", {7'd36, 2'b00}, 32'h0);
        rd_chk("R8 no alias ch4", {7'd4, 2'b00}, 32'h0);

        // R5 with protection, loss flag stays clear on a protected channel
        conv(1'b0, 7'd80, 10'h011, 2'd1);
        conv(1'b0, 7'd80, 10'h022, 2'd2);
        rd_chk("R5 protected keep", {7'd80, 2'b00}, 32'h00090011);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk("R1 after reset ch63", {7'd63, 2'b00}, 32'h0);
        rd_chk("R1 after reset ch20", {7'd20, 2'b00}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule